// File: doc/BRIEF.md
# Q31 Fractional Multiply Unit

This unit multiplies two signed 32-bit words and returns a single 32-bit word taken from the 64-bit signed product. A two-bit mode input selects how that word is formed. It can be the plain upper half of the product. It can be the upper half after a rounding step, which makes the truncation error symmetric. It can be a correctly scaled fractional (Q31) product, which doubles the upper half, brings in the top bit of the lower half, and clamps the one value that cannot be represented.

The unit accepts a new operation on every clock. It has two register stages, so each result appears exactly two cycles after its operands. A flag marks each result that was clamped. The full 64-bit product is also presented, aligned with the result, as an observation port.

Top module: `q31mul_unit`

## Requirements
- R1: `dbg_product` carries the full signed 64-bit product of `op_a` and `op_b`, aligned with `result`.
- R2: With mode 2'b00 (truncate), `result` equals product bits 63:32.
- R3: With mode 2'b01 (round), `result` equals bits 63:32 of the product plus 0x0000_0000_8000_0000.
- R4: With mode 2'b10 (Q31), `result` equals product bits 62:31 whenever bits 63 and 62 agree.
- R5: With mode 2'b10, 0x80000000 times 0x80000000 gives `result` 0x7FFFFFFF and `sat_flag` high.
- R6: `sat_flag` is high only on an output cycle whose Q31 result was clamped. A clamped result is 0x7FFFFFFF or 0x80000000. The flag is low for every other mode and cycle.
- R7: With modes 2'b00 and 2'b01, 0x80000000 times 0x80000000 gives 0x40000000 and no flag.
- R8: Mode 2'b11 behaves exactly like truncate.
- R9: `out_valid` follows `in_valid` two cycles later. Back-to-back operations are accepted on every cycle.
- R10: A synchronous active-high `rst` clears `out_valid` and `sat_flag` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 2 | 00 truncate, 01 round, 10 Q31 saturate, 11 truncate |
| op_a | input | 32 | Signed multiplicand |
| op_b | input | 32 | Signed multiplier |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Selected 32-bit word |
| sat_flag | output | 1 | Q31 result was clamped |
| dbg_product | output | 64 | Full product, aligned with result |

## Verification
The most negative operand squared separates the three modes. It yields 0x40000000 in truncate and round modes and a clamped 0x7FFFFFFF with the flag in Q31 mode. The pairs most-negative by most-positive and most-positive squared show whether bit 31 of the low word is shifted in, and whether rounding carries into the upper word. Random operands, modes and valid gaps exercise all four mode codes at full rate. They also show that idle cycles produce no valid output. A reset issued while operations are in flight shows that the pipeline is flushed.

// File: rtl/q31mul_pkg.sv
package q31mul_pkg;
    localparam int WORD_W = 32;
    localparam int PROD_W = 2 * WORD_W;

    typedef enum logic [1:0] {
        MODE_TRUNC = 2'b00,
        MODE_ROUND = 2'b01,
        MODE_FRAC  = 2'b10,
        MODE_ALIAS = 2'b11
    } fmode_e;

    typedef struct packed {
        logic                     vld;
        fmode_e                   mode;
        logic [PROD_W-1:0]        prod;
    } prod_stage_t;

    typedef struct packed {
        logic                     vld;
        logic                     sat;
        logic [WORD_W-1:0]        word;
        logic [PROD_W-1:0]        prod;
    } out_stage_t;
endpackage

// File: rtl/q31mul_mult.sv
module q31mul_mult #(
    parameter int W = 32
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;

    always_comb begin
        a_ext = {{W{a[W-1]}}, a};
        b_ext = {{W{b[W-1]}}, b};
        p     = a_ext * b_ext;
    end
endmodule

// File: rtl/q31mul_shape.sv
module q31mul_shape
    import q31mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2*W-1:0] prod,
    input  fmode_e         mode,
    output logic [W-1:0]   word,
    output logic           sat
);
    localparam int PW = 2 * W;
    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] hi_word;
    logic [W-1:0] rnd_word;
    logic [W-1:0] frac_word;
    logic         frac_ovf;

    always_comb begin
        hi_word   = prod[PW-1:W];
        rnd_word  = hi_word + {{(W-1){1'b0}}, prod[W-1]};
        frac_ovf  = prod[PW-1] ^ prod[PW-2];
        if (frac_ovf) begin
            frac_word = prod[PW-1] ? NEG_LIM : POS_LIM;
        end else begin
            frac_word = prod[PW-2:W-1];
        end

        sat = 1'b0;
        unique case (mode)
            MODE_ROUND: word = rnd_word;
            MODE_FRAC: begin
                word = frac_word;
                sat  = frac_ovf;
            end
            default:    word = hi_word;
        endcase
    end
endmodule

// File: rtl/q31mul_unit.sv
module q31mul_unit
    import q31mul_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [1:0]     mode,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic           out_valid,
    output logic [W-1:0]   result,
    output logic           sat_flag,
    output logic [2*W-1:0] dbg_product
);
    localparam int PW = 2 * W;

    typedef struct packed {
        logic          vld;
        fmode_e        mode;
        logic [PW-1:0] prod;
    } s1_t;

    typedef struct packed {
        logic          vld;
        logic          sat;
        logic [W-1:0]  word;
        logic [PW-1:0] prod;
    } s2_t;

    s1_t s1_d, s1_q;
    s2_t s2_d, s2_q;

    logic [PW-1:0] mul_p;
    logic [W-1:0]  shp_word;
    logic          shp_sat;

    q31mul_mult #(.W(W)) u_mult (
        .a (op_a),
        .b (op_b),
        .p (mul_p)
    );

    q31mul_shape #(.W(W)) u_shape (
        .prod (s1_q.prod),
        .mode (s1_q.mode),
        .word (shp_word),
        .sat  (shp_sat)
    );

    always_comb begin
        s1_d      = s1_q;
        s1_d.vld  = in_valid;
        s1_d.mode = fmode_e'(mode);
        s1_d.prod = mul_p;

        s2_d      = s2_q;
        s2_d.vld  = s1_q.vld;
        s2_d.sat  = s1_q.vld & shp_sat;
        s2_d.word = shp_word;
        s2_d.prod = s1_q.prod;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid   = s2_q.vld;
    assign sat_flag    = s2_q.sat;
    assign result      = s2_q.word;
    assign dbg_product = s2_q.prod;
endmodule

// File: rtl/q31mul_chk.sv
module q31mul_chk #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [1:0]     mode,
    input logic [W-1:0]   op_a,
    input logic [W-1:0]   op_b,
    input logic           out_valid,
    input logic [W-1:0]   result,
    input logic           sat_flag,
    input logic [2*W-1:0] dbg_product
);
    localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] QUART = {2'b01, {(W-2){1'b0}}};

    logic min_sq;
    assign min_sq = (op_a == MIN_V) && (op_b == MIN_V);

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);
    a_r9_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);
    a_r5_min_square_clamps: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b10 && min_sq) |-> ##2 (sat_flag && result == MAX_V));
    a_r7_min_square_plain: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode != 2'b10 && min_sq) |-> ##2 (!sat_flag && result == QUART));
    a_r6_flag_non_frac_low: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode != 2'b10) |-> ##2 !sat_flag);
    a_r6_flag_value: assert property (@(posedge clk) disable iff (rst)
        sat_flag |-> (out_valid && (result == MAX_V || result == MIN_V)));
    a_r2_trunc_word: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b00) |-> ##2 (result == dbg_product[2*W-1:W]));
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && !sat_flag));
endmodule

bind q31mul_unit q31mul_chk #(.W(W)) u_chk (.*);

// File: tb/sim_q31mul_unit.sv
`timescale 1ns/1ps
module sim_q31mul_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        sat_flag;
    logic [63:0] dbg_product;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          vld;
        bit          sat;
        logic [31:0] word;
        logic [63:0] prod;
        string       tag;
    } exp_t;

    exp_t pend[$];

    always #2.5 clk = ~clk;

    q31mul_unit u0 (.*);

    function automatic exp_t model(bit v, logic [1:0] m, logic [31:0] a, logic [31:0] b);
        exp_t   e;
        longint p;
        longint q;
        p = longint'($signed(a)) * longint'($signed(b));
        e.vld  = v;
        e.prod = p;
        e.sat  = 1'b0;
        case (m)
            2'b01: begin
                e.word = 32'((p + 64'sd2147483648) >>> 32);
                e.tag  = "R3";
            end
            2'b10: begin
                q = p >>> 31;
                if (q > 64'sd2147483647) begin
                    e.word = 32'h7FFF_FFFF; e.sat = 1'b1; e.tag = "R5";
                end else if (q < -64'sd2147483648) begin
                    e.word = 32'h8000_0000; e.sat = 1'b1; e.tag = "R5";
                end else begin
                    e.word = 32'(q); e.tag = "R4";
                end
            end
            2'b11: begin
                e.word = 32'(p >>> 32);
                e.tag  = "R8";
            end
            default: begin
                e.word = 32'(p >>> 32);
                e.tag  = "R2";
            end
        endcase
        if (a == 32'h8000_0000 && b == 32'h8000_0000 && m != 2'b10) e.tag = "R7";
        return e;
    endfunction

    task automatic compare(exp_t e);
        checks++;
        if (out_valid !== e.vld) begin
            errors++;
            $display("FAIL R9 out_valid actual %0b expected %0b", out_valid, e.vld);
        end
        if (e.vld) begin
            checks++;
            if (result !== e.word) begin
                errors++;
                $display("FAIL %s result actual %h expected %h", e.tag, result, e.word);
            end
            checks++;
            if (sat_flag !== e.sat) begin
                errors++;
                $display("FAIL R6 sat_flag actual %0b expected %0b", sat_flag, e.sat);
            end
            checks++;
            if (dbg_product !== e.prod) begin
                errors++;
                $display("FAIL R1 product actual %h expected %h", dbg_product, e.prod);
            end
        end else begin
            checks++;
            if (sat_flag !== 1'b0) begin
                errors++;
                $display("FAIL R6 idle sat_flag actual %0b expected 0", sat_flag);
            end
        end
    endtask

    task automatic step(bit v, logic [1:0] m, logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        if (pend.size() >= 2) compare(pend.pop_front());
        in_valid = v; mode = m; op_a = a; op_b = b;
        pend.push_back(model(v, m, a, b));
    endtask

    task automatic drain();
        for (int i = 0; i < 2; i++) step(1'b0, 2'b00, '0, '0);
    endtask

    task automatic reset_check();
        checks++;
        if (out_valid !== 1'b0 || sat_flag !== 1'b0) begin
            errors++;
            $display("FAIL R10 after reset valid/flag actual %0b/%0b expected 0/0",
                     out_valid, sat_flag);
        end
    endtask

    initial begin
        logic [31:0] corners [3][2];
        corners[0][0] = 32'h8000_0000; corners[0][1] = 32'h8000_0000;
        corners[1][0] = 32'h8000_0000; corners[1][1] = 32'h7FFF_FFFF;
        corners[2][0] = 32'h7FFF_FFFF; corners[2][1] = 32'h7FFF_FFFF;

        repeat (3) @(negedge clk);
        reset_check();
        rst = 1'b0;

        // R5 R7 R2 R3 R4 R8: corner pairs in every mode, back to back (R9)
        for (int c = 0; c < 3; c++)
            for (int m = 0; m < 4; m++)
                step(1'b1, 2'(m), corners[c][0], corners[c][1]);
        // rounding carry into the upper word (R3) and small values (R4)
        step(1'b1, 2'b01, 32'h0000_0001, 32'h8000_0000);
        step(1'b1, 2'b01, 32'hFFFF_FFFF, 32'h8000_0000);
        step(1'b1, 2'b10, 32'h4000_0000, 32'h4000_0000);
        step(1'b1, 2'b10, 32'hC000_0000, 32'h4000_0000);
        step(1'b1, 2'b10, 32'h0000_0000, 32'h8000_0000);
        drain();

        // random operands, modes and gaps
        for (int i = 0; i < 400; i++)
            step(($urandom % 4) != 0, 2'($urandom), $urandom, $urandom);
        drain();

        // R10: reset with operations in flight
        step(1'b1, 2'b10, 32'h8000_0000, 32'h8000_0000);
        step(1'b1, 2'b10, 32'h8000_0000, 32'h8000_0000);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        reset_check();
        pend.delete();
        rst = 1'b0;
        for (int i = 0; i < 2; i++) step(1'b0, 2'b00, '0, '0);
        step(1'b0, 2'b00, '0, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule